// File: doc/BRIEF.md
# Interrupt Pending and Mask Controller

This block collects one-cycle request pulses from up to eleven peripherals into a pending register. It then drives a single interrupt line toward the processor whenever a pending source is also enabled in a mask register. Software reaches both registers through a small register bus with a 32-bit data lane. A 16-bit access uses the low half of the lane, and a 32-bit access carries nothing in its upper half.

To acknowledge a source, software writes a word in which that source's bit is zero. The controller keeps the AND of the old pending value and the written word, so any bit written as one stays as it was. The mask register takes the written value directly. The interrupt line is worked out from the current pending and mask contents, so it follows any write to either register from the next cycle. Request input 3 is meant for the DMA interrupt logic, but the controller treats it like any other source.

Top module: `irq_ctrl`

## Requirements
- R1: While reset is high at a clock edge, pending and mask are cleared to zero, and the interrupt line is low after that edge.
- R2: A pulse on request input k (k from 0 to 10) sets pending bit k at that clock edge. The bit stays set until software acknowledges it.
- R3: A write to byte offset 0x70 (bus_wr high) sets pending to the old pending value ANDed with bus_wdata[10:0]. A written zero clears a bit and a written one leaves it unchanged.
- R4: A write to byte offset 0x74 loads the mask register with bus_wdata[10:0].
- R5: cpu_irq is high exactly when some bit is set in both pending and mask. A write to either register changes cpu_irq in the cycle after that write's clock edge.
- R6: When a request pulse and an acknowledge write that clears the same bit arrive at the same edge, the bit ends up set. Other bits are cleared as written.
- R7: A read (bus_rd high) of offset 0x70 returns pending, and a read of offset 0x74 returns mask, in bits 10:0 in the same cycle. Bits 31:11 read as zero.
- R8: Bits 31:11 of a write have no effect on either register.
- R9: A write to any other offset changes neither register, and a read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset within the I/O window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wdata | input | 32 | Write data lane |
| bus_rdata | output | 32 | Read data lane, zero when no register is read |
| irq_req | input | 11 | Request pulses, one bit per source; bit 3 is the DMA source |
| cpu_irq | output | 1 | Interrupt line to the processor |

## Verification
The bench fires a request pulse on the same edge as an acknowledge write that clears that bit. A design that lets the clear win drops an interrupt, and the later read shows zero. Mask writes that both raise and drop the line check that the line follows mask writes as well as pending writes. A design that only updates the line on pending changes would leave it stale. Writes with the upper half fully set, and writes and reads at an unrelated offset, show whether upper bits leak into the registers, whether decode aliases other offsets onto a register, and whether a miss returns bus garbage. A mid-run reset with a high line checks that both registers clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int MAX_SRC  = 16;

    localparam logic [ADDR_W-1:0] PEND_OFS = 8'h70;
    localparam logic [ADDR_W-1:0] MASK_OFS = 8'h74;

    typedef struct packed {
        logic pend_wr;
        logic mask_wr;
        logic pend_rd;
        logic mask_rd;
    } irqc_access_t;

    function automatic logic hits(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] ofs);
        return a == ofs;
    endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output irqc_access_t      acc
);
    logic at_pend;
    logic at_mask;

    always_comb begin
        at_pend     = hits(addr, PEND_OFS);
        at_mask     = hits(addr, MASK_OFS);
        acc.pend_wr = wr & at_pend;
        acc.mask_wr = wr & at_mask;
        acc.pend_rd = rd & at_pend;
        acc.mask_rd = rd & at_mask;
    end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req,
    input  logic               ack_we,
    input  logic [NUM_SRC-1:0] ack_val,
    output logic [NUM_SRC-1:0] pend
);
    logic [NUM_SRC-1:0] keep;

    always_comb begin
        keep = ack_we ? ack_val : {NUM_SRC{1'b1}};
    end

    // requests are ORed in after the acknowledge AND, so a set wins
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend <= (pend & keep) | req;
        end
    end
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [NUM_SRC-1:0] val,
    output logic [NUM_SRC-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (we) begin
            mask <= val;
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] irq_req,
    output logic               cpu_irq
);
    localparam int PAD_W = DATA_W - NUM_SRC;

    irqc_access_t       acc;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] wval;

    initial begin
        if (NUM_SRC < 1 || NUM_SRC > MAX_SRC)
            $error("NUM_SRC must be 1..%0d", MAX_SRC);
    end

    assign wval = bus_wdata[NUM_SRC-1:0];

    irqc_decode u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .acc  (acc)
    );

    irqc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .req     (irq_req),
        .ack_we  (acc.pend_wr),
        .ack_val (wval),
        .pend    (pend_q)
    );

    irqc_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk  (clk),
        .rst  (rst),
        .we   (acc.mask_wr),
        .val  (wval),
        .mask (mask_q)
    );

    always_comb begin
        unique case (1'b1)
            acc.pend_rd: bus_rdata = {{PAD_W{1'b0}}, pend_q};
            acc.mask_rd: bus_rdata = {{PAD_W{1'b0}}, mask_q};
            default:     bus_rdata = '0;
        endcase
    end

    assign cpu_irq = |(pend_q & mask_q);
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 11
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] irq_req,
    input logic               cpu_irq,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] mask
);
    logic pwr;
    logic mwr;
    assign pwr = bus_wr && (bus_addr == 8'h70);
    assign mwr = bus_wr && (bus_addr == 8'h74);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pend == '0 && mask == '0 && !cpu_irq)); // R1

    AST_REQ_SETS: assert property (@(posedge clk) disable iff (rst)
        (irq_req != '0) |=> ((pend & $past(irq_req)) == $past(irq_req))); // R2

    AST_ACK_AND: assert property (@(posedge clk) disable iff (rst)
        (pwr && irq_req == '0) |=> (pend == ($past(pend) & $past(bus_wdata[NUM_SRC-1:0])))); // R3

    AST_MASK_STORE: assert property (@(posedge clk) disable iff (rst)
        mwr |=> (mask == $past(bus_wdata[NUM_SRC-1:0]))); // R4

    AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mwr && bus_wdata[NUM_SRC-1:0] == '0) |=> !cpu_irq); // R5

    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> (bus_rdata[DATA_W-1:NUM_SRC] == '0)); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!pwr && !mwr && irq_req == '0) |=> ($stable(pend) && $stable(mask))); // R9
endmodule

bind irq_ctrl irqc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req),
    .cpu_irq   (cpu_irq),
    .pend      (pend_q),
    .mask      (mask_q)
);

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;

    localparam int NS = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NS-1:0] irq_req = '0;
    logic        cpu_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_ctrl #(.NUM_SRC(NS)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .cpu_irq(cpu_irq)
    );

    // kind: 0 = request pulse only, 1 = write (with req), 2 = read
    typedef struct packed {
        logic [1:0]    kind;
        logic [7:0]    addr;
        logic [31:0]   data;
        logic [NS-1:0] req;
        logic [31:0]   exp;
        logic          exp_irq;
        logic [3:0]    tag;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h00, 32'h0,        11'h001, 32'h0,   1'b0, 4'd2}, // R2
        '{2'd2, 8'h70, 32'h0,        11'h000, 32'h001, 1'b0, 4'd2}, // R2
        '{2'd1, 8'h74, 32'h1,        11'h000, 32'h0,   1'b1, 4'd5}, // R5
        '{2'd2, 8'h74, 32'h0,        11'h000, 32'h001, 1'b1, 4'd4}, // R4
        '{2'd0, 8'h00, 32'h0,        11'h408, 32'h0,   1'b1, 4'd2}, // R2
        '{2'd2, 8'h70, 32'h0,        11'h000, 32'h409, 1'b1, 4'd2}, // R2
        '{2'd1, 8'h70, 32'hFFFFFFFE, 11'h000, 32'h0,   1'b0, 4'd3}, // R3
        '{2'd2, 8'h70, 32'h0,        11'h000, 32'h408, 1'b0, 4'd3}, // R3
        '{2'd1, 8'h74, 32'hFFFF0408, 11'h000, 32'h0,   1'b1, 4'd5}, // R5
        '{2'd2, 8'h74, 32'h0,        11'h000, 32'h408, 1'b1, 4'd8}, // R8
        '{2'd1, 8'h70, 32'h00000008, 11'h000, 32'h0,   1'b1, 4'd3}, // R3
        '{2'd2, 8'h70, 32'h0,        11'h000, 32'h008, 1'b1, 4'd3}, // R3
        '{2'd1, 8'h70, 32'h0,        11'h000, 32'h0,   1'b0, 4'd5}, // R5
        '{2'd1, 8'h60, 32'hFFFFFFFF, 11'h000, 32'h0,   1'b0, 4'd9}, // R9
        '{2'd2, 8'h60, 32'h0,        11'h000, 32'h0,   1'b0, 4'd9}, // R9
        '{2'd1, 8'h74, 32'hFFFFFFFF, 11'h000, 32'h0,   1'b0, 4'd7}, // R7
        '{2'd2, 8'h74, 32'h0,        11'h000, 32'h7FF, 1'b0, 4'd7}  // R7
    };

    task automatic check(input int tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_cycle(input logic wr, input logic [7:0] a,
                            input logic [31:0] d, input logic [NS-1:0] r);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; irq_req = r;
        @(negedge clk);
        bus_wr = 1'b0; irq_req = '0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        do_read(8'h70, v); check(1, "pending after reset", v, 32'h0);
        do_read(8'h74, v); check(1, "mask after reset", v, 32'h0);
        check(1, "irq after reset", {31'b0, cpu_irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].kind == 2'd2) begin
                do_read(VECS[i].addr, v);
                check(int'(VECS[i].tag), "read data", v, VECS[i].exp);
            end else begin
                do_cycle(VECS[i].kind == 2'd1, VECS[i].addr, VECS[i].data, VECS[i].req);
            end
            check(int'(VECS[i].tag), "irq line", {31'b0, cpu_irq}, {31'b0, VECS[i].exp_irq});
        end

        // R6: request wins over a same-edge clear of the same bit
        do_cycle(1'b0, 8'h00, 32'h0, 11'h014);
        do_cycle(1'b1, 8'h70, 32'h0, 11'h004);
        do_read(8'h70, v); check(6, "set beats clear", v, 32'h004);
        check(6, "irq after race", {31'b0, cpu_irq}, 32'h1);

        // R5: dropping the mask drops the line
        do_cycle(1'b1, 8'h74, 32'h0, '0);
        check(5, "irq after mask clear", {31'b0, cpu_irq}, 32'h0);
        do_cycle(1'b1, 8'h74, 32'h4, '0);
        check(5, "irq after mask set", {31'b0, cpu_irq}, 32'h1);

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(1, "irq after mid reset", {31'b0, cpu_irq}, 32'h0);
        do_read(8'h70, v); check(1, "pending after mid reset", v, 32'h0);
        do_read(8'h74, v); check(1, "mask after mid reset", v, 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule